// File: doc/BRIEF.md
# Parity-Checked Registered Bus Transceiver

An 8-bit registered transceiver that sits between two buses, an A side and a B side. Each direction has its own storage register. It also has its own load strobe with an active-low qualifier and its own active-low output enable. The A-to-B register drives the B side together with a generated parity bit. The B-to-A register captures the B-side word and a received parity bit, and reports a parity error when that side is read out.

Each direction has a handshake flag. Loading the register raises the flag. The reader lowers it again by returning that direction's output enable from low to high. All sequential logic runs on one free-running system clock, `clk_i`. The load strobes and the output enables are sampled on that clock, and their rising edges are detected there. Tri-state pins appear as separate data and enable outputs.

Top module: `prty_xcvr`

## Requirements
- R1: On a system clock edge where the A-to-B strobe `r_clk_i` is seen rising (high now, low at the previous edge) and `r_ce_ni` is low, the A-to-B register takes `a_i`. It holds its value at every other edge.
- R2: Each A-to-B load sets `fr_o` high, and it reads high right after that edge.
- R3: `b_oe_o` and `par_oe_o` equal the inverse of `oe_ab_ni`. `b_o` always shows the A-to-B register.
- R4: `par_o` is 1 when the A-to-B register holds an even number of ones, including zero ones. The nine bits therefore always have odd parity.
- R5: A rising edge of `oe_ab_ni` seen on the system clock clears `fr_o` at that edge. If a load happens at the same edge, the flag is set instead.
- R6: On a rising `s_clk_i` with `s_ce_ni` low, the B-to-A register takes `b_i` and a separate parity register takes `par_i`. The same edge sets `fs_o`, and a clear at that edge loses to the set. At every other edge both registers hold.
- R7: `a_oe_o` equals the inverse of `oe_ba_ni`, and `a_o` shows the B-to-A register. A rising edge of `oe_ba_ni` clears `fs_o`.
- R8: While `oe_ba_ni` is low, `err_o` is 1 when the B-to-A register plus the parity register hold an odd count of ones, and 0 when the count is even (a parity error). While `oe_ba_ni` is high, `err_o` is 1.
- R9: A low on `rst_ni` asynchronously clears both data registers, the parity register and both flags. Neither a strobe nor an enable that is high when reset ends counts as a rising edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | free-running system clock |
| rst_ni | input | 1 | asynchronous reset, active low |
| r_clk_i | input | 1 | A-to-B load strobe |
| r_ce_ni | input | 1 | A-to-B load qualifier, active low |
| s_clk_i | input | 1 | B-to-A load strobe |
| s_ce_ni | input | 1 | B-to-A load qualifier, active low |
| oe_ab_ni | input | 1 | B-side output enable, active low; rising edge clears fr_o |
| oe_ba_ni | input | 1 | A-side output enable, active low; rising edge clears fs_o |
| a_i | input | 8 | A-side input data |
| a_o | output | 8 | A-side output data |
| a_oe_o | output | 1 | A-side drive enable |
| b_i | input | 8 | B-side input data |
| b_o | output | 8 | B-side output data |
| b_oe_o | output | 1 | B-side drive enable |
| par_i | input | 1 | received parity bit |
| par_o | output | 1 | generated parity bit |
| par_oe_o | output | 1 | parity pin drive enable |
| err_o | output | 1 | parity check result, low on error |
| fr_o | output | 1 | A-to-B data-ready flag |
| fs_o | output | 1 | B-to-A data-ready flag |

## Verification
Register contents and flags change at the first system clock edge where the strobe or enable level differs from the previous sample. They are visible from that edge on, with no added latency. The drive enables, `par_o` and `err_o` follow the current enable levels combinationally. The bench drives inputs at the falling edge and compares every output 3 ns later against a behavioural model advanced at each rising edge. Each comparison therefore sees the state from the last edge together with the present inputs.

// File: rtl/xfer_pkg.sv
package xfer_pkg;
  localparam int unsigned DATA_W = 8;
endpackage

// File: rtl/xfer_edge.sv
module xfer_edge #(
  parameter logic IDLE = 1'b1
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic sig_i,
  output logic rise_o
);
  logic sig_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sig_q <= IDLE;
    else         sig_q <= sig_i;
  end

  assign rise_o = sig_i & ~sig_q;
endmodule

// File: rtl/xfer_lane.sv
module xfer_lane #(
  parameter int unsigned DW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          stb_i,
  input  logic          ce_ni,
  input  logic          oe_ni,
  input  logic [DW-1:0] d_i,
  output logic [DW-1:0] q_o,
  output logic          flag_o
);
  logic stb_rise, oe_rise, load;

  xfer_edge #(.IDLE(1'b1)) u_stb (
    .clk_i(clk_i), .rst_ni(rst_ni), .sig_i(stb_i), .rise_o(stb_rise)
  );
  xfer_edge #(.IDLE(1'b1)) u_oe (
    .clk_i(clk_i), .rst_ni(rst_ni), .sig_i(oe_ni), .rise_o(oe_rise)
  );

  assign load = stb_rise & ~ce_ni;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   q_o <= '0;
    else if (load) q_o <= d_i;
  end

  // set wins over clear
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      flag_o <= 1'b0;
    else if (load)    flag_o <= 1'b1;
    else if (oe_rise) flag_o <= 1'b0;
  end

  // R1 / R6: qualifier high means no capture
  a_r1_r6_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ce_ni |=> $stable(q_o));
  // R2 / R6: load raises the flag
  a_r2_r6_set: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (stb_rise && !ce_ni) |=> flag_o);
  // R5 / R7: enable release clears flag unless a load collides
  a_r5_r7_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (oe_rise && !(stb_rise && !ce_ni)) |=> !flag_o);
endmodule

// File: rtl/prty_xcvr.sv
module prty_xcvr
  import xfer_pkg::*;
#(
  parameter int unsigned W = DATA_W
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         r_clk_i,
  input  logic         r_ce_ni,
  input  logic         s_clk_i,
  input  logic         s_ce_ni,
  input  logic         oe_ab_ni,
  input  logic         oe_ba_ni,
  input  logic [W-1:0] a_i,
  output logic [W-1:0] a_o,
  output logic         a_oe_o,
  input  logic [W-1:0] b_i,
  output logic [W-1:0] b_o,
  output logic         b_oe_o,
  input  logic         par_i,
  output logic         par_o,
  output logic         par_oe_o,
  output logic         err_o,
  output logic         fr_o,
  output logic         fs_o
);
  localparam int unsigned SW = W + 1;  // S word plus received parity

  logic [W-1:0]  r_q;
  logic [SW-1:0] s_q;

  xfer_lane #(.DW(W)) u_r (
    .clk_i(clk_i), .rst_ni(rst_ni), .stb_i(r_clk_i), .ce_ni(r_ce_ni),
    .oe_ni(oe_ab_ni), .d_i(a_i), .q_o(r_q), .flag_o(fr_o)
  );

  xfer_lane #(.DW(SW)) u_s (
    .clk_i(clk_i), .rst_ni(rst_ni), .stb_i(s_clk_i), .ce_ni(s_ce_ni),
    .oe_ni(oe_ba_ni), .d_i({par_i, b_i}), .q_o(s_q), .flag_o(fs_o)
  );

  assign b_o      = r_q;
  assign b_oe_o   = ~oe_ab_ni;
  assign par_o    = ~(^r_q);
  assign par_oe_o = ~oe_ab_ni;

  assign a_o    = s_q[W-1:0];
  assign a_oe_o = ~oe_ba_ni;
  assign err_o  = oe_ba_ni | (^s_q);

  // R4: driven nine bits carry odd parity
  a_r4_odd_nine: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !oe_ab_ni |-> (^{b_o, par_o}) == 1'b1);
  // R8: no error reported while A side is idle
  a_r8_err_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    oe_ba_ni |-> err_o);
endmodule

// File: tb/sim_prty_xcvr.sv
`timescale 1ns/1ps
module sim_prty_xcvr;
  logic clk = 1'b0, rst_n = 1'b0;
  logic r_clk = 0, r_ce_n = 1, s_clk = 0, s_ce_n = 1, oe_ab_n = 1, oe_ba_n = 1;
  logic [7:0] a_in = 0, b_in = 0;
  logic par_in = 0;
  logic [7:0] a_out, b_out;
  logic a_oe, b_oe, par_out, par_oe, err, fr, fs;
  int n_tests = 0, n_fail = 0;
  bit done = 0;

  always #5 clk = ~clk;

  prty_xcvr u0 (
    .clk_i(clk), .rst_ni(rst_n), .r_clk_i(r_clk), .r_ce_ni(r_ce_n),
    .s_clk_i(s_clk), .s_ce_ni(s_ce_n), .oe_ab_ni(oe_ab_n), .oe_ba_ni(oe_ba_n),
    .a_i(a_in), .a_o(a_out), .a_oe_o(a_oe), .b_i(b_in), .b_o(b_out),
    .b_oe_o(b_oe), .par_i(par_in), .par_o(par_out), .par_oe_o(par_oe),
    .err_o(err), .fr_o(fr), .fs_o(fs)
  );

  // behavioural reference
  logic [7:0] m_r, m_s;
  logic m_p, m_fr, m_fs, p_rclk, p_sclk, p_oeab, p_oeba;

  function automatic int ones(input logic [8:0] v);
    int c = 0;
    for (int i = 0; i < 9; i++) c += v[i];
    return c;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_r = 0; m_s = 0; m_p = 0; m_fr = 0; m_fs = 0;
      p_rclk = 1; p_sclk = 1; p_oeab = 1; p_oeba = 1;
    end else begin
      bit ldr, lds, clr_r, clr_s;
      ldr = r_clk && !p_rclk && !r_ce_n;
      lds = s_clk && !p_sclk && !s_ce_n;
      clr_r = oe_ab_n && !p_oeab;
      clr_s = oe_ba_n && !p_oeba;
      if (ldr) m_r = a_in;
      if (lds) begin m_s = b_in; m_p = par_in; end
      if (ldr) m_fr = 1; else if (clr_r) m_fr = 0;
      if (lds) m_fs = 1; else if (clr_s) m_fs = 0;
      p_rclk = r_clk; p_sclk = s_clk; p_oeab = oe_ab_n; p_oeba = oe_ba_n;
    end
  end

  task automatic chk(input string tag, input logic [7:0] got, input logic [7:0] exp);
    n_tests++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s got %h exp %h at %0t", tag, got, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    #3;
    if (!done) begin
      chk("R1/R9 b_o", b_out, m_r);
      chk("R3 b_oe_o", {7'd0, b_oe}, {7'd0, !oe_ab_n});
      chk("R3 par_oe_o", {7'd0, par_oe}, {7'd0, !oe_ab_n});
      chk("R4 par_o", {7'd0, par_out}, {7'd0, ones({1'b0, m_r}) % 2 == 0});
      chk("R2/R5/R9 fr_o", {7'd0, fr}, {7'd0, m_fr});
      chk("R6/R7/R9 a_o", a_out, m_s);
      chk("R7 a_oe_o", {7'd0, a_oe}, {7'd0, !oe_ba_n});
      chk("R6/R7/R9 fs_o", {7'd0, fs}, {7'd0, m_fs});
      chk("R8 err_o", {7'd0, err},
          {7'd0, oe_ba_n ? 1'b1 : (ones({m_p, m_s}) % 2 == 1)});
    end
  end

  task automatic cyc(input int n = 1);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic load_r(input logic [7:0] v, input logic ce);
    a_in = v; r_ce_n = ce; r_clk = 1; cyc(); r_clk = 0; r_ce_n = 1; cyc();
  endtask

  task automatic load_s(input logic [7:0] v, input logic p, input logic ce);
    b_in = v; par_in = p; s_ce_n = ce; s_clk = 1; cyc(); s_clk = 0; s_ce_n = 1; cyc();
  endtask

  initial begin
    // R9: strobes/enables high during reset give no edge afterwards
    r_clk = 1; s_clk = 1;
    cyc(3);
    rst_n = 1; r_ce_n = 0; s_ce_n = 0;
    cyc(2);
    r_clk = 0; s_clk = 0; r_ce_n = 1; s_ce_n = 1;
    cyc(2);
    // R1/R2/R4
    load_r(8'h00, 0);
    load_r(8'hA5, 0);
    load_r(8'h3C, 1);          // held: qualifier high
    oe_ab_n = 0; cyc(3);        // R3 drive
    load_r(8'h07, 0);
    oe_ab_n = 1; cyc(2);        // R5 clear
    // R5: set and clear at same edge
    oe_ab_n = 0; cyc(2);
    a_in = 8'hFF; r_ce_n = 0; r_clk = 1; oe_ab_n = 1; cyc();
    r_clk = 0; r_ce_n = 1; cyc(2);
    // R6/R8 good and bad parity
    load_s(8'h81, 1'b1, 0);
    oe_ba_n = 0; cyc(2);
    load_s(8'h81, 1'b0, 0);
    cyc(2);
    load_s(8'h00, 1'b0, 1);    // held
    oe_ba_n = 1; cyc(2);        // R7 clear
    // R6: set beats clear
    oe_ba_n = 0; cyc();
    b_in = 8'h5A; par_in = 1; s_ce_n = 0; s_clk = 1; oe_ba_n = 1; cyc();
    s_clk = 0; s_ce_n = 1; cyc(2);
    // random traffic
    for (int i = 0; i < 3000; i++) begin
      r_clk = $urandom; r_ce_n = $urandom; s_clk = $urandom; s_ce_n = $urandom;
      oe_ab_n = $urandom; oe_ba_n = $urandom;
      a_in = $urandom; b_in = $urandom;
      par_in = oe_ab_n ? 1'($urandom) : 1'b0;
      if (i == 1500) rst_n = 0;
      if (i == 1504) rst_n = 1;
      cyc();
    end
    cyc();
    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    #1_000_000;
    if (!done) begin
      done = 1;
      n_tests++; n_fail++;
      $display("FAIL watchdog got timeout exp completion");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end
endmodule